// File: doc/BRIEF.md
# DSI Packet Assembler

This block turns packet requests into the serial byte stream that a display serial interface lane serializer consumes. A request names the packet kind, a 6-bit data type, a 2-bit virtual channel and two header data bytes. For a short packet those two bytes are the packet's data. For a long or blanking packet they form the 16-bit word count. The block emits a 4-byte header whose last byte is a 6-bit error-correcting code. For long packets it then forwards the payload bytes from a valid/ready input stream and closes the packet with a 16-bit checksum. Blanking packets carry no caller payload: the block repeats one fill byte for the requested length and computes the checksum over those repeated bytes.

The output is a valid/ready byte stream with start-of-packet and end-of-packet markers. Only one packet is in flight at a time. A request is taken only while the block is idle, so the caller holds its request until the block accepts it.

Top module: `dsi_pkt_builder`

## Requirements
- R1: Header byte 0 is {vc[1:0], dt[5:0]}. Byte 1 is d0 and byte 2 is d1. For long and blanking packets, d0 is the low byte and d1 the high byte of the word count.
- R2: Header byte 3 is an ECC over h = {byte2, byte1, byte0}. ECC bit i is the XOR-reduction of h masked with one fixed value: bit0 0xF12CB7, bit1 0xF2555B, bit2 0x749A6D, bit3 0xB8E38E, bit4 0xDF03F0, bit5 0xEFFC00. Bits 7:6 are zero.
- R3: A long or blanking packet ends with a checksum over its payload bytes only, sent low byte first. The checksum is processed least significant bit first with reflected polynomial 0x8408 and preset 0xFFFF; the ASCII bytes "123456789" give 0x6F91.
- R4: When req_kind bit 1 is set, the packet is a blanking packet. Data type 0x19 replaces req_dt, and the payload is req_fill repeated word-count times. pl_ready stays low for the whole packet, so payload input has no effect.
- R5: A long packet with word count zero sends its header followed directly by 0xFF, 0xFF.
- R6: req_kind 2'b00 sends a 4-byte short packet. req_kind 2'b01 sends a long packet of word count + 6 bytes. out_sop marks the first header byte. out_eop marks the ECC byte of a short packet or the high checksum byte of a long one. The first byte is offered in the cycle after acceptance.
- R7: req_ready is high only while idle. A request held or changed while the block is busy does not alter the packet in progress, and the block is idle again in the cycle after the end byte is taken.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop hold, provided the payload source also holds.
- R9: During a long packet's payload, out_valid follows pl_valid and pl_ready follows out_ready. Payload bytes appear in order and unchanged.
- R10: After reset, req_ready is high and out_valid and pl_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request strobe |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_kind | input | 2 | 00 short, 01 long, 1x blanking |
| req_dt | input | 6 | Data type (ignored for blanking) |
| req_vc | input | 2 | Virtual channel |
| req_d0 | input | 8 | Short data byte 0 or word count low byte |
| req_d1 | input | 8 | Short data byte 1 or word count high byte |
| req_fill | input | 8 | Pad byte for blanking payload |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte taken |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_ready | input | 1 | Serializer takes the output byte |

## Verification
Two events can fall in the same cycle: the handshake of a packet's end byte, and a request that is already waiting at the input. The bench provokes this by keeping req_valid high through whole packets while changing the request fields to a different short packet. It judges the result byte by byte against its own expected stream, and it checks that req_ready stays low until the cycle after the end byte. A second overlap is a checksum update together with output back-pressure. Random out_ready and pl_valid patterns stall the payload mid-byte, and both the held output values and the final checksum are compared with values computed in the bench.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_CRC  = 2'd3
  } pkt_state_e;

  localparam int BYTE_W = 8;
  localparam int HDR_W  = 3 * BYTE_W;
  localparam int WC_W   = 2 * BYTE_W;
  localparam int ECC_W  = 6;

  localparam logic [5:0] DT_BLANKING = 6'h19;

  localparam logic [HDR_W-1:0] ECC_MASK [ECC_W] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D,
    24'hB8E38E, 24'hDF03F0, 24'hEFFC00
  };

  // One byte of the reflected checksum, least significant bit first.
  function automatic logic [15:0] crc_fold_byte(input logic [15:0] cur,
                                                input logic [7:0]  din,
                                                input logic [15:0] poly);
    logic [15:0] c;
    c = cur;
    for (int b = 0; b < BYTE_W; b++) begin
      if (c[0] ^ din[b]) c = (c >> 1) ^ poly;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/dsi_ecc_gen.sv
module dsi_ecc_gen
  import dsi_pkt_pkg::*;
(
  input  logic [HDR_W-1:0]  hdr,
  output logic [BYTE_W-1:0] ecc
);

  for (genvar i = 0; i < ECC_W; i++) begin : g_parity
    assign ecc[i] = ^(hdr & ECC_MASK[i]);
  end

  assign ecc[BYTE_W-1:ECC_W] = '0;

endmodule

// File: rtl/dsi_crc_acc.sv
module dsi_crc_acc
  import dsi_pkt_pkg::*;
#(
  parameter logic [15:0] PRESET = 16'hFFFF,
  parameter logic [15:0] POLY_R = 16'h8408
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [15:0]       crc
);

  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= PRESET;
    else if (clr) crc <= PRESET;
    else if (en)  crc <= crc_fold_byte(crc, din, POLY_R);
  end

  // every packet starts its checksum from the preset
  p_preset_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == PRESET));

endmodule

// File: rtl/dsi_pkt_builder.sv
module dsi_pkt_builder
  import dsi_pkt_pkg::*;
#(
  parameter logic [15:0] CRC_PRESET = 16'hFFFF,
  parameter logic [15:0] CRC_POLY_R = 16'h8408
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [5:0]        req_dt,
  input  logic [1:0]        req_vc,
  input  logic [BYTE_W-1:0] req_d0,
  input  logic [BYTE_W-1:0] req_d1,
  input  logic [BYTE_W-1:0] req_fill,
  input  logic              pl_valid,
  input  logic [BYTE_W-1:0] pl_data,
  output logic              pl_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              out_ready
);

  pkt_state_e        st;
  logic [1:0]        idx;
  logic [WC_W-1:0]   remain;
  logic              short_q, blank_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [BYTE_W-1:0] fill_q;
  logic [BYTE_W-1:0] ecc;
  logic [15:0]       crc;

  // named events shared by the datapath and the assertions
  logic            req_fire, out_fire, pay_fire, hdr_last, pay_last, crc_last;
  logic [WC_W-1:0] wc;

  assign req_ready = (st == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign out_fire  = out_valid && out_ready;
  assign pay_fire  = (st == ST_PAY) && out_fire;
  assign hdr_last  = (st == ST_HDR) && (idx == 2'd3) && out_fire;
  assign pay_last  = pay_fire && (remain == WC_W'(1));
  assign crc_last  = (st == ST_CRC) && idx[0] && out_fire;
  assign wc        = hdr_q[HDR_W-1:BYTE_W];

  dsi_ecc_gen u_ecc (
    .hdr (hdr_q),
    .ecc (ecc)
  );

  dsi_crc_acc #(
    .PRESET (CRC_PRESET),
    .POLY_R (CRC_POLY_R)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (req_fire),
    .en    (pay_fire),
    .din   (out_data),
    .crc   (crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      remain  <= '0;
      short_q <= 1'b0;
      blank_q <= 1'b0;
      hdr_q   <= '0;
      fill_q  <= '0;
    end else begin
      if (req_fire) begin
        st      <= ST_HDR;
        idx     <= '0;
        blank_q <= req_kind[1];
        short_q <= (req_kind == 2'b00);
        fill_q  <= req_fill;
        hdr_q   <= {req_d1, req_d0, req_vc, (req_kind[1] ? DT_BLANKING : req_dt)};
      end
      if (out_fire) begin
        unique case (st)
          ST_HDR: begin
            idx <= idx + 2'd1;
            if (hdr_last) begin
              if (short_q)          st <= ST_IDLE;
              else if (wc == '0)    st <= ST_CRC;
              else begin
                st     <= ST_PAY;
                remain <= wc;
              end
            end
          end
          ST_PAY: begin
            remain <= remain - WC_W'(1);
            if (pay_last) begin
              st  <= ST_CRC;
              idx <= '0;
            end
          end
          ST_CRC: begin
            idx <= 2'd1;
            if (crc_last) begin
              st  <= ST_IDLE;
              idx <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    pl_ready  = 1'b0;
    unique case (st)
      ST_HDR: begin
        out_valid = 1'b1;
        out_sop   = (idx == 2'd0);
        out_eop   = (idx == 2'd3) && short_q;
        unique case (idx)
          2'd0:    out_data = hdr_q[7:0];
          2'd1:    out_data = hdr_q[15:8];
          2'd2:    out_data = hdr_q[23:16];
          default: out_data = ecc;
        endcase
      end
      ST_PAY: begin
        if (blank_q) begin
          out_valid = 1'b1;
          out_data  = fill_q;
        end else begin
          out_valid = pl_valid;
          out_data  = pl_data;
          pl_ready  = out_ready;
        end
      end
      ST_CRC: begin
        out_valid = 1'b1;
        out_data  = idx[0] ? crc[15:8] : crc[7:0];
        out_eop   = idx[0];
      end
      default: ;
    endcase
  end

  p_first_byte_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (out_valid && out_sop));

  p_end_returns_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_eop) |=> req_ready);

  p_idle_no_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  p_payload_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> out_ready);

  p_blank_no_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_q && !req_ready) |-> !pl_ready);

endmodule

// File: tb/sim_dsi_pkt_builder.sv
`timescale 1ns/1ps
module sim_dsi_pkt_builder;

  typedef struct {
    logic [7:0] d;
    logic       sop;
    logic       eop;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = '0;
  logic [5:0] req_dt = '0;
  logic [1:0] req_vc = '0;
  logic [7:0] req_d0 = '0, req_d1 = '0, req_fill = '0;
  logic       pl_valid = 1'b0;
  logic [7:0] pl_data = '0;
  logic       pl_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sop, out_eop;
  logic       out_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  dsi_pkt_builder u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_dt(req_dt), .req_vc(req_vc), .req_d0(req_d0), .req_d1(req_d1),
    .req_fill(req_fill),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // header check code, written bit by bit
  function automatic logic [7:0] ecc_ref(input logic [23:0] h);
    logic [7:0] e;
    e = '0;
    e[0] = h[0]^h[1]^h[2]^h[4]^h[5]^h[7]^h[10]^h[11]^h[13]^h[16]^h[20]^h[21]^h[22]^h[23];
    e[1] = h[0]^h[1]^h[3]^h[4]^h[6]^h[8]^h[10]^h[12]^h[14]^h[17]^h[20]^h[21]^h[22]^h[23];
    e[2] = h[0]^h[2]^h[3]^h[5]^h[6]^h[9]^h[11]^h[12]^h[15]^h[18]^h[20]^h[21]^h[22];
    e[3] = h[1]^h[2]^h[3]^h[7]^h[8]^h[9]^h[13]^h[14]^h[15]^h[19]^h[20]^h[21]^h[23];
    e[4] = h[4]^h[5]^h[6]^h[7]^h[8]^h[9]^h[16]^h[17]^h[18]^h[19]^h[20]^h[22]^h[23];
    e[5] = h[10]^h[11]^h[12]^h[13]^h[14]^h[15]^h[16]^h[17]^h[18]^h[19]^h[21]^h[22]^h[23];
    return e;
  endfunction

  // checksum in the non-reflected form on bit-reversed data
  function automatic logic [15:0] crc_ref(input logic [7:0] bytes_in[$]);
    logic [15:0] r;
    logic [15:0] o;
    logic [7:0]  d;
    r = 16'hFFFF;
    foreach (bytes_in[i]) begin
      for (int k = 0; k < 8; k++) d[k] = bytes_in[i][7-k];
      for (int k = 7; k >= 0; k--) begin
        if (r[15] ^ d[k]) r = (r << 1) ^ 16'h1021;
        else              r = r << 1;
      end
    end
    for (int k = 0; k < 16; k++) o[k] = r[15-k];
    return o;
  endfunction

  task automatic push_exp(input logic [7:0] d, input logic s, input logic e, input string t);
    exp_t x;
    x.d = d; x.sop = s; x.eop = e; x.tag = t;
    exp_q.push_back(x);
  endtask

  task automatic build_exp(input logic [1:0] kind, input logic [5:0] dt, input logic [1:0] vc,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] fill,
                           input logic [7:0] pay[$], input bit force_crc,
                           input logic [15:0] crc_lit);
    logic [7:0]  b0;
    logic [23:0] h;
    logic [15:0] n, c;
    logic [7:0]  body[$];
    bit          is_short;
    is_short = (kind == 2'b00);
    b0 = {vc, (kind[1] ? 6'h19 : dt)};
    h  = {d1, d0, b0};
    exp_q.delete();
    push_exp(b0, 1'b1, 1'b0, "R1");
    push_exp(d0, 1'b0, 1'b0, "R1");
    push_exp(d1, 1'b0, 1'b0, "R1");
    push_exp(ecc_ref(h), 1'b0, is_short, "R2");
    if (!is_short) begin
      n = {d1, d0};
      for (int i = 0; i < int'(n); i++) begin
        body.push_back(kind[1] ? fill : pay[i]);
        push_exp(body[i], 1'b0, 1'b0, kind[1] ? "R4" : "R9");
      end
      c = force_crc ? crc_lit : crc_ref(body);
      push_exp(c[7:0],  1'b0, 1'b0, (n == 0) ? "R5" : "R3");
      push_exp(c[15:8], 1'b0, 1'b1, (n == 0) ? "R5" : "R3");
    end
  endtask

  task automatic run_pkt(input logic [1:0] kind, input logic [5:0] dt, input logic [1:0] vc,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] fill,
                         input logic [7:0] pay[$], input bit hold,
                         input bit force_crc, input logic [15:0] crc_lit);
    bit accepted, was_acc, done, stall_prev, pl_pend;
    int pi, oi;
    logic [7:0] s_data;
    logic s_sop, s_eop;
    build_exp(kind, dt, vc, d0, d1, fill, pay, force_crc, crc_lit);
    accepted = 0; done = 0; stall_prev = 0; pl_pend = 0; pi = 0; oi = 0;
    s_data = '0; s_sop = 0; s_eop = 0;
    @(negedge clk);
    req_kind = kind; req_dt = dt; req_vc = vc; req_d0 = d0; req_d1 = d1; req_fill = fill;
    req_valid = 1'b1;
    pl_valid = 1'b0;
    while (!done) begin
      if (accepted) begin
        if (hold) begin
          req_kind = 2'b00; req_dt = ~dt; req_vc = ~vc; req_d0 = ~d0; req_d1 = ~d1;
        end else begin
          req_valid = 1'b0;
        end
      end
      out_ready = ($urandom % 4) != 0;
      if (!pl_pend) begin
        if (kind[1]) begin
          pl_valid = $urandom % 2;
          pl_data  = $urandom;
        end else begin
          pl_valid = (pi < pay.size()) && (($urandom % 3) != 0);
          pl_data  = (pi < pay.size()) ? pay[pi] : 8'h00;
        end
      end
      #1;
      was_acc = accepted;
      if (stall_prev) begin
        check(out_valid && out_data == s_data && out_sop == s_sop && out_eop == s_eop,
              "R8", "held byte", {out_valid, out_sop, out_eop, out_data},
              {1'b1, s_sop, s_eop, s_data});
      end
      if (was_acc) check(!req_ready, "R7", "req_ready while busy", req_ready, 0);
      if (was_acc && kind[1]) check(!pl_ready, "R4", "pl_ready in blanking", pl_ready, 0);
      if (!was_acc && req_valid && req_ready) accepted = 1;
      pl_pend = pl_valid && !pl_ready;
      if (pl_valid && pl_ready) pi++;
      if (out_valid && out_ready) begin
        if (oi < exp_q.size()) begin
          check(out_data == exp_q[oi].d && out_sop == exp_q[oi].sop && out_eop == exp_q[oi].eop,
                exp_q[oi].tag, $sformatf("byte %0d {sop,eop,data}", oi),
                {out_sop, out_eop, out_data}, {exp_q[oi].sop, exp_q[oi].eop, exp_q[oi].d});
        end
        oi++;
        if (out_eop || oi >= exp_q.size()) done = 1;
      end
      stall_prev = out_valid && !out_ready;
      s_data = out_data; s_sop = out_sop; s_eop = out_eop;
      @(negedge clk);
    end
    check(oi == exp_q.size(), "R6", "packet length", oi, exp_q.size());
    req_valid = 1'b0;
    pl_valid  = 1'b0;
    #1;
    check(req_ready && !out_valid, "R7", "idle after end byte", {req_ready, out_valid}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] pay[$];
    logic [7:0] none[$];
    logic [15:0] n;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    #1;
    check(req_ready && !out_valid && !pl_ready, "R10", "reset state",
          {req_ready, out_valid, pl_ready}, 3'b100);
    rst_n = 1'b1;

    // short packet, request held through it
    run_pkt(2'b00, 6'h15, 2'd2, 8'h36, 8'hA5, 8'h00, none, 1'b1, 1'b0, 16'h0);
    // long packet with the known checksum
    pay = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    run_pkt(2'b01, 6'h39, 2'd1, 8'd9, 8'd0, 8'h00, pay, 1'b0, 1'b1, 16'h6F91);
    // empty long packet
    run_pkt(2'b01, 6'h29, 2'd3, 8'd0, 8'd0, 8'h00, none, 1'b1, 1'b1, 16'hFFFF);
    // blanking packet, kind 2'b11 also counts as blanking
    run_pkt(2'b10, 6'h02, 2'd0, 8'd7, 8'd0, 8'h5A, none, 1'b1, 1'b0, 16'h0);
    run_pkt(2'b11, 6'h3F, 2'd1, 8'd0, 8'd0, 8'hC3, none, 1'b0, 1'b0, 16'h0);

    for (int t = 0; t < 40; t++) begin
      logic [1:0] k;
      k = $urandom % 4;
      n = $urandom % 24;
      pay.delete();
      if (k == 2'b01) for (int i = 0; i < int'(n); i++) pay.push_back($urandom);
      run_pkt(k, $urandom, $urandom, (k == 2'b00) ? 8'($urandom) : n[7:0],
              (k == 2'b00) ? 8'($urandom) : 8'h00, $urandom, pay, $urandom % 2,
              1'b0, 16'h0);
    end
    finish_run();
  end

endmodule